// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter with Chainable Carry

This block is an up-counter whose width is set at compile time (four bits unless overridden). All state changes happen on the rising clock edge. An active-low clear has the highest priority. An active-low parallel load comes next and copies an external value into the count. Increment comes last.

Two enables gate the increment, and the count advances only when both are high. The second enable, the chain enable, also qualifies the terminal-count carry. This lets several counters be cascaded into a wider one: the carry of one stage drives the chain enable of the next. The carry is combinational, so a cascade ripples through in the same cycle.

Top module: `pcnt_top`

## Requirements
- R1: With `rst_ni` low at a rising clock edge, `count_o` becomes 0 after that edge, whatever the load strobe, load value and enables are.
- R2: With `rst_ni` high and `load_ni` low at a rising edge, `count_o` becomes `load_val_i` after that edge, whatever the enables are.
- R3: With `rst_ni` and `load_ni` both high and both `cnt_en_i` and `chain_en_i` high, `count_o` increases by one at the edge.
- R4: With `rst_ni` and `load_ni` both high and either enable low, `count_o` keeps its value across the edge.
- R5: Incrementing from the all-ones value gives zero (modulo 2^WIDTH wrap).
- R6: `carry_o` is 1 exactly when `count_o` is all ones and `chain_en_i` is 1, in the same cycle, with no register delay.
- R7: `carry_o` does not depend on `cnt_en_i`: at all ones with `chain_en_i` high, carry is 1 whether `cnt_en_i` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous clear, active low, highest priority |
| load_val_i | input | WIDTH | Parallel value for load |
| load_ni | input | 1 | Parallel load strobe, active low |
| cnt_en_i | input | 1 | Count enable (increment only) |
| chain_en_i | input | 1 | Count enable that also qualifies the carry |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal-count carry, combinational |

## Verification
The bench builds the counter with the default width of four bits. At this width the full count space is only sixteen values, so the rollover from all ones to zero and the carry at terminal count are reached within a handful of increments. Loads placed near the top of the range, such as 14, cross the wrap boundary quickly. The stimulus also sets the controls against each other: clear with load active, load with both enables high, and each enable dropped alone. Together these exercise the priority order and the gating of the carry.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  // Next-state selection, listed in increasing priority
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } pcnt_op_e;
endpackage

// File: rtl/pcnt_ctrl.sv
module pcnt_ctrl
  import pcnt_pkg::*;
(
  input  logic     rst_ni,
  input  logic     load_ni,
  input  logic     cnt_en_i,
  input  logic     chain_en_i,
  output pcnt_op_e op_o
);
  always_comb begin
    if (!rst_ni)                      op_o = OP_CLR;
    else if (!load_ni)                op_o = OP_LOAD;
    else if (cnt_en_i && chain_en_i)  op_o = OP_INC;
    else                              op_o = OP_HOLD;
  end
endmodule

// File: rtl/pcnt_inc.sv
module pcnt_inc #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] c;
  assign c[0] = 1'b1;

  // Half-adder ripple; final carry doubles as the all-ones detect
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_o[i] = q_i[i] ^ c[i];
    assign c[i+1]   = q_i[i] & c[i];
  end
  assign cout_o = c[WIDTH];

  always_comb begin
    if (!$isunknown(q_i)) begin
      // R5
      inc_wrap_chk: assert (!cout_o || sum_o == '0);
    end
  end
endmodule

// File: rtl/pcnt_top.sv
module pcnt_top
  import pcnt_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             load_ni,
  input  logic             cnt_en_i,
  input  logic             chain_en_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  pcnt_op_e         op;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] inc_val;
  logic             at_top;

  pcnt_ctrl u_ctrl (
    .rst_ni    (rst_ni),
    .load_ni   (load_ni),
    .cnt_en_i  (cnt_en_i),
    .chain_en_i(chain_en_i),
    .op_o      (op)
  );

  pcnt_inc #(.WIDTH(WIDTH)) u_inc (
    .q_i   (count_q),
    .sum_o (inc_val),
    .cout_o(at_top)
  );

  always_ff @(posedge clk_i) begin
    case (op)
      OP_CLR:  count_q <= '0;
      OP_LOAD: count_q <= load_val_i;
      OP_INC:  count_q <= inc_val;
      default: count_q <= count_q;
    endcase
  end

  assign count_o = count_q;
  assign carry_o = at_top & chain_en_i;

  // R1
  clr_chk: assert property (@(posedge clk_i)
    !rst_ni |=> count_o == '0);

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(load_val_i));

  // R3
  inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni && cnt_en_i && chain_en_i |=> count_o == WIDTH'($past(count_o) + 1'b1));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni && !(cnt_en_i && chain_en_i) |=> $stable(count_o));

  // R6
  carry_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni && cnt_en_i && carry_o |=> count_o == '0);
endmodule

// File: tb/pcnt_top_tb_top.sv
`timescale 1ns/1ps
module pcnt_top_tb_top;
  localparam int unsigned W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] load_val_i = '0;
  logic         load_ni = 1'b1;
  logic         cnt_en_i = 1'b0;
  logic         chain_en_i = 1'b0;
  logic [W-1:0] count_o;
  logic         carry_o;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int unsigned cycles = 0;
  bit           done = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] model_q;
  bit           model_ok = 1'b0;

  always #10 clk_i = ~clk_i;

  pcnt_top #(.WIDTH(W)) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_val_i(load_val_i),
    .load_ni   (load_ni),
    .cnt_en_i  (cnt_en_i),
    .chain_en_i(chain_en_i),
    .count_o   (count_o),
    .carry_o   (carry_o)
  );

  task automatic step(input logic r, input logic l, input logic [W-1:0] v,
                      input logic ce, input logic te, input string tag);
    logic         exp_c;
    logic [W-1:0] nxt;
    @(negedge clk_i);
    rst_ni = r; load_ni = l; load_val_i = v; cnt_en_i = ce; chain_en_i = te;
    #2;
    if (model_ok) begin
      exp_c = (model_q == {W{1'b1}}) && te;
      n_cmp++;
      if (carry_o !== exp_c) begin
        n_bad++;
        $display("FAIL R6 R7 (%s) carry actual %0b expected %0b", tag, carry_o, exp_c);
      end
    end
    if (!r)           nxt = '0;
    else if (!l)      nxt = v;
    else if (ce & te) nxt = model_q + 1'b1;
    else              nxt = model_q;
    model_q  = nxt;
    model_ok = 1'b1;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  // Monitor: sample mid-high-phase after each edge
  always @(posedge clk_i) begin
    #5;
    if (exp_q.size() != 0) begin
      logic [W-1:0] e;
      string        t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (count_o !== e) begin
        n_bad++;
        $display("FAIL %s count actual %0h expected %0h", t, count_o, e);
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 clear wins over load and enables
    step(1'b0, 1'b0, 4'h9, 1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, 4'h0, 1'b1, 1'b1, "R1");
    // R2 load with enables off and on
    step(1'b1, 1'b0, 4'h5, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b0, 4'hA, 1'b1, 1'b1, "R2");
    // R3 count
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, "R3");
    // R4 hold with each enable low
    step(1'b1, 1'b1, 4'h3, 1'b0, 1'b1, "R4");
    step(1'b1, 1'b1, 4'h3, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b1, 4'h3, 1'b0, 1'b0, "R4");
    // R5 wrap from load near top
    step(1'b1, 1'b0, 4'hE, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, "R5");
    // at all ones: R7 carry with count enable low, R6 carry gated by chain enable
    step(1'b1, 1'b1, 4'h0, 1'b0, 1'b1, "R7");
    step(1'b1, 1'b1, 4'h0, 1'b1, 1'b0, "R6");
    step(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, "R5");
    step(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, "R3");
    // R1 clear from mid count
    step(1'b0, 1'b1, 4'h0, 1'b1, 1'b1, "R1");
    // full lap to revisit wrap and carry
    for (int i = 0; i < 18; i++) step(1'b1, 1'b1, 4'h0, 1'b1, 1'b1, "R5");
    step(1'b1, 1'b1, 4'h0, 1'b0, 1'b0, "R4");
    repeat (3) @(negedge clk_i);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule